// File: doc/BRIEF.md
# Two-Class Nested Bus-Access Arbiter

This block decides which of two requester classes may use one shared serial bus. The first class is a power-management agent, and the second is a host driver. Either class may take the bus more than once in a nested fashion. The block keeps one nesting count per class and never lets both counts be nonzero together. Only the host's first acquisition pays the handoff cost. That cost is a begin event, a deep-low-power inhibit, and a request to an external hardware semaphore that must be acknowledged. Nested host acquisitions are granted at once. When the last host hold is released, the block returns the semaphore, lifts the inhibit and signals an end event.

Each class uses a level request, a single-cycle grant and a single-cycle release pulse. A requester holds its request high until it sees the grant. The acquisition completes at the rising edge where request and grant are both high, and the requester drops the request after that edge.

The control state machine has seven states:
- IDLE: no host ownership.
- BEGIN: the begin pulse.
- INHIBIT: the inhibit is raised.
- SEMWAIT: the semaphore is requested, with the acknowledge, refusal and timeout checked.
- OWN: the host holds the bus.
- END: the normal hand-back.
- FAIL: the failed hand-back.

The transitions are:
- IDLE to BEGIN on a host request when no agent holds the bus and no agent is being granted.
- BEGIN to INHIBIT, and INHIBIT to SEMWAIT, unconditionally.
- SEMWAIT to OWN on acknowledge.
- SEMWAIT to FAIL on refusal or timeout.
- OWN to END when the last host hold is released.
- END to IDLE, and FAIL to IDLE, unconditionally.

Top module: `bus_share_arbiter`

## Requirements
- R1: After reset, every grant, error, event, semaphore request, inhibit and underflow output is low, and both nesting counts are zero.
- R2: In IDLE, a held agent request (agt_req) is granted combinationally in that cycle (agt_gnt) and raises the agent count by one. Repeated agent acquisitions nest, and each agent release lowers the count by one. Agent activity never produces a begin or end event.
- R3: While the agent count is nonzero, a host request produces no begin event, no semaphore request and no grant. Once the last agent release lands, the host handoff starts from IDLE.
- R4: A first host acquisition follows a fixed cycle order:
  - evt_begin is high for exactly the one cycle after the accepting edge;
  - lp_inhibit rises in the next cycle;
  - sem_req rises one cycle after that, together with the held inhibit;
  - hst_gnt is asserted combinationally in the cycle that sem_ack is high.

  Counted in clock cycles from the cycle the request is first seen in IDLE, the grant appears in the fourth cycle. sem_req and lp_inhibit stay high while the host count is nonzero.
- R5: A host request while the host count is nonzero is granted combinationally in the same cycle, with no begin event.
- R6: While the host count is nonzero, agent requests are never granted. After the host end, the pending agent request is granted in the first IDLE cycle.
- R7: A host release that leaves the count nonzero changes no output. The release that brings the count to zero puts the block in END for one cycle: evt_end is high, and sem_req and lp_inhibit are low.
- R8: If sem_nak is high in SEMWAIT, the next cycle is FAIL: hst_err and evt_end pulse together, sem_req and lp_inhibit are low, and no grant is given. The host count stays zero, so the next host acquisition again starts with a begin event.
- R9: If neither acknowledge nor refusal arrives within SEM_TIMEOUT cycles of SEMWAIT, the block enters FAIL with the same outputs and count behaviour as in R8.
- R10: A release pulse on a class whose count is zero leaves that count unchanged and sets that class's sticky underflow flag (agt_uflow or hst_uflow). The flag stays set until reset, and the other class's flag is unaffected.
- R11: When both classes request in the same IDLE cycle, the agent is granted and the host waits.
- R12: Agent and host grants are never high together, and the two counts are never nonzero together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| agt_req | input | 1 | Agent acquire request, held until granted |
| agt_rel | input | 1 | Agent release pulse |
| agt_gnt | output | 1 | Agent grant, one cycle |
| hst_req | input | 1 | Host acquire request, held until grant or error |
| hst_rel | input | 1 | Host release pulse |
| hst_gnt | output | 1 | Host grant, one cycle |
| hst_err | output | 1 | Host acquisition failed (refusal or timeout) |
| sem_ack | input | 1 | Hardware semaphore acknowledge |
| sem_nak | input | 1 | Hardware semaphore refusal |
| sem_req | output | 1 | Request/hold of the hardware semaphore |
| lp_inhibit | output | 1 | Deep-low-power entry inhibit |
| evt_begin | output | 1 | Host ownership begin event pulse |
| evt_end | output | 1 | Host ownership end event pulse |
| agt_uflow | output | 1 | Sticky agent release-at-zero flag |
| hst_uflow | output | 1 | Sticky host release-at-zero flag |

## Verification
A wrong host count shows up at the ports within one acquisition or release:
- If the count was kept too low, a nested host request produces a fresh begin event instead of an immediate grant.
- If the count was kept too high, a final release produces no end pulse, and sem_req and lp_inhibit stay stuck high.

A wrong agent count shows up as a host request that stalls without a begin event, or as a release that sets the underflow flag one cycle after it lands. A wrong state-machine step is visible as a shifted position of evt_begin, lp_inhibit, sem_req or the grant. The bench pins each of these to an exact cycle.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_BEGIN,
        S_INHIBIT,
        S_SEMWAIT,
        S_OWN,
        S_END,
        S_FAIL
    } arb_state_t;
endpackage

// File: rtl/bsa_nest_counter.sv
module bsa_nest_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         is_zero,
    output logic         is_one,
    output logic         is_full,
    output logic         uflow
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] MAXV = '1;

    logic dec_ok;

    assign is_zero = (count == '0);
    assign is_one  = (count == ONE);
    assign is_full = (count == MAXV);
    assign dec_ok  = dec && !is_zero;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            uflow <= 1'b0;
        end else begin
            if (dec && is_zero) begin
                uflow <= 1'b1;
            end
            count <= count + {{(W-1){1'b0}}, inc} - {{(W-1){1'b0}}, dec_ok};
        end
    end
endmodule

// File: rtl/bsa_hold_timer.sv
module bsa_hold_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + TW'(1);
        end
    end
endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter #(
    parameter int CNT_W       = 4,
    parameter int SEM_TIMEOUT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic agt_req,
    input  logic agt_rel,
    output logic agt_gnt,
    input  logic hst_req,
    input  logic hst_rel,
    output logic hst_gnt,
    output logic hst_err,
    input  logic sem_ack,
    input  logic sem_nak,
    output logic sem_req,
    output logic lp_inhibit,
    output logic evt_begin,
    output logic evt_end,
    output logic agt_uflow,
    output logic hst_uflow
);
    import bsa_pkg::*;

    arb_state_t state, state_nx;

    logic [CNT_W-1:0] agt_cnt, hst_cnt;
    logic agt_zero, agt_one, agt_full;
    logic hst_zero, hst_one, hst_full;
    logic sem_timeout;
    logic sem_waiting;

    assign sem_waiting = (state == S_SEMWAIT);

    bsa_nest_counter #(.W(CNT_W)) u_agt_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (agt_gnt),
        .dec     (agt_rel),
        .count   (agt_cnt),
        .is_zero (agt_zero),
        .is_one  (agt_one),
        .is_full (agt_full),
        .uflow   (agt_uflow)
    );

    bsa_nest_counter #(.W(CNT_W)) u_hst_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (hst_gnt),
        .dec     (hst_rel),
        .count   (hst_cnt),
        .is_zero (hst_zero),
        .is_one  (hst_one),
        .is_full (hst_full),
        .uflow   (hst_uflow)
    );

    bsa_hold_timer #(.LIMIT(SEM_TIMEOUT)) u_sem_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (sem_waiting),
        .expired (sem_timeout)
    );

    // Grants: agent only when no host ownership; host nested or on acknowledge
    always_comb begin
        agt_gnt = (state == S_IDLE) && agt_req && !agt_full;
        hst_gnt = ((state == S_SEMWAIT) && hst_req && sem_ack) ||
                  ((state == S_OWN) && hst_req && !hst_full);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (hst_req && agt_zero && !agt_gnt) state_nx = S_BEGIN;
            S_BEGIN:   state_nx = S_INHIBIT;
            S_INHIBIT: state_nx = S_SEMWAIT;
            S_SEMWAIT: begin
                if (hst_gnt) begin
                    state_nx = S_OWN;
                end else if (sem_nak || sem_timeout) begin
                    state_nx = S_FAIL;
                end
            end
            S_OWN:     if (hst_rel && hst_one && !hst_gnt) state_nx = S_END;
            S_END:     state_nx = S_IDLE;
            S_FAIL:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        evt_begin  = 1'b0;
        evt_end    = 1'b0;
        lp_inhibit = 1'b0;
        sem_req    = 1'b0;
        hst_err    = 1'b0;
        unique case (state)
            S_IDLE:    ;
            S_BEGIN:   evt_begin = 1'b1;
            S_INHIBIT: lp_inhibit = 1'b1;
            S_SEMWAIT: begin
                lp_inhibit = 1'b1;
                sem_req    = 1'b1;
            end
            S_OWN: begin
                lp_inhibit = 1'b1;
                sem_req    = 1'b1;
            end
            S_END:     evt_end = 1'b1;
            S_FAIL: begin
                evt_end = 1'b1;
                hst_err = 1'b1;
            end
            default:   ;
        endcase
    end
endmodule

// File: rtl/bus_share_arbiter_chk.sv
module bus_share_arbiter_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         agt_gnt,
    input logic         hst_gnt,
    input logic         hst_err,
    input logic         sem_req,
    input logic         lp_inhibit,
    input logic         evt_begin,
    input logic         evt_end,
    input logic         agt_uflow,
    input logic         hst_uflow,
    input logic [W-1:0] agt_cnt,
    input logic [W-1:0] hst_cnt
);
    // R12
    grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(agt_gnt && hst_gnt));

    // R12
    class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((agt_cnt != '0) && (hst_cnt != '0)));

    // R2
    agt_gnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        agt_gnt |-> (hst_cnt == '0) && !lp_inhibit && !sem_req);

    // R4
    begin_then_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_begin |=> lp_inhibit && !sem_req && !evt_begin);

    // R4
    sem_needs_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sem_req |-> lp_inhibit);

    // R4
    hgnt_sem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_gnt |-> sem_req);

    // R7
    end_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_end |-> !sem_req && !lp_inhibit && !evt_begin);

    // R8
    err_with_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_err |-> evt_end && !hst_gnt && (hst_cnt == '0));

    // R10
    agt_uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        agt_uflow |=> agt_uflow);

    // R10
    hst_uf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hst_uflow |=> hst_uflow);
endmodule

bind bus_share_arbiter bus_share_arbiter_chk #(.W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .agt_gnt    (agt_gnt),
    .hst_gnt    (hst_gnt),
    .hst_err    (hst_err),
    .sem_req    (sem_req),
    .lp_inhibit (lp_inhibit),
    .evt_begin  (evt_begin),
    .evt_end    (evt_end),
    .agt_uflow  (agt_uflow),
    .hst_uflow  (hst_uflow),
    .agt_cnt    (agt_cnt),
    .hst_cnt    (hst_cnt)
);

// File: tb/bus_share_arbiter_bench.sv
`timescale 1ns/1ps
module bus_share_arbiter_bench;
    localparam int TMO     = 64;
    localparam int LOOPMAX = 300;

    // op codes
    localparam logic [2:0] OP_AACQ = 3'd0;
    localparam logic [2:0] OP_AREL = 3'd1;
    localparam logic [2:0] OP_HACK = 3'd2;
    localparam logic [2:0] OP_HNAK = 3'd3;
    localparam logic [2:0] OP_HREL = 3'd4;

    // entry: {req tag, op, gnt, err, begin, end, latency}
    localparam int NV = 13;
    localparam logic [18:0] TBL [NV] = '{
        {4'd2, OP_AACQ, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1}, // R2
        {4'd2, OP_AACQ, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1}, // R2 nested
        {4'd2, OP_AREL, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0}, // R2
        {4'd2, OP_AREL, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0}, // R2
        {4'd4, OP_HACK, 1'b1, 1'b0, 1'b1, 1'b0, 8'd4}, // R4 first host
        {4'd5, OP_HACK, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1}, // R5 nested host
        {4'd7, OP_HREL, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0}, // R7 inner release
        {4'd7, OP_HREL, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0}, // R7 last release
        {4'd8, OP_HNAK, 1'b0, 1'b1, 1'b1, 1'b1, 8'd5}, // R8 refusal
        {4'd8, OP_HACK, 1'b1, 1'b0, 1'b1, 1'b0, 8'd4}, // R8 count stayed zero
        {4'd7, OP_HREL, 1'b0, 1'b0, 1'b0, 1'b1, 8'd0}, // R7
        {4'd2, OP_AACQ, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1}, // R2
        {4'd2, OP_AREL, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0}  // R2
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic agt_req = 1'b0, agt_rel = 1'b0;
    logic hst_req = 1'b0, hst_rel = 1'b0;
    logic sem_ack = 1'b0, sem_nak = 1'b0;
    logic agt_gnt, hst_gnt, hst_err, sem_req, lp_inhibit;
    logic evt_begin, evt_end, agt_uflow, hst_uflow;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    bus_share_arbiter #(.CNT_W(4), .SEM_TIMEOUT(TMO)) u_bus_share_arbiter (
        .clk        (clk),
        .rst_n      (rst_n),
        .agt_req    (agt_req),
        .agt_rel    (agt_rel),
        .agt_gnt    (agt_gnt),
        .hst_req    (hst_req),
        .hst_rel    (hst_rel),
        .hst_gnt    (hst_gnt),
        .hst_err    (hst_err),
        .sem_ack    (sem_ack),
        .sem_nak    (sem_nak),
        .sem_req    (sem_req),
        .lp_inhibit (lp_inhibit),
        .evt_begin  (evt_begin),
        .evt_end    (evt_end),
        .agt_uflow  (agt_uflow),
        .hst_uflow  (hst_uflow)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic agt_acq(output bit got, output int lat);
        got = 0; lat = 0;
        agt_req = 1'b1;
        for (int i = 1; i <= LOOPMAX; i++) begin
            @(negedge clk);
            if (agt_gnt) begin got = 1; lat = i; break; end
        end
        @(posedge clk); #1;
        agt_req = 1'b0;
    endtask

    // resp: 0 none, 1 acknowledge, 2 refuse
    task automatic hst_acq(input int resp, output bit got, output bit err,
                           output bit beg, output bit en, output int lat);
        got = 0; err = 0; beg = 0; en = 0; lat = 0;
        hst_req = 1'b1;
        for (int i = 1; i <= LOOPMAX; i++) begin
            @(negedge clk);
            if (evt_begin) beg = 1;
            if (evt_end) en = 1;
            if (hst_err) begin err = 1; lat = i; break; end
            if (hst_gnt) begin got = 1; lat = i; break; end
            if (sem_req && resp == 1) sem_ack = 1'b1;
            if (sem_req && resp == 2) sem_nak = 1'b1;
            #1;
            if (hst_gnt) begin got = 1; lat = i; break; end
        end
        @(posedge clk); #1;
        hst_req = 1'b0; sem_ack = 1'b0; sem_nak = 1'b0;
    endtask

    // release pulse, then sample the cycle after the releasing edge
    task automatic rel_pulse(input bit host, output bit en, output bit sr, output bit lp);
        if (host) hst_rel = 1'b1; else agt_rel = 1'b1;
        @(posedge clk); #1;
        hst_rel = 1'b0; agt_rel = 1'b0;
        @(negedge clk);
        en = evt_end; sr = sem_req; lp = lp_inhibit;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit g, e, b, en, sr, lp, saw;
        int lat;
        logic [18:0] ent;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 outputs after reset",
              {agt_gnt, hst_gnt, hst_err, sem_req, lp_inhibit, evt_begin, evt_end, agt_uflow, hst_uflow},
              0);
        @(posedge clk); #1;

        // table walk
        for (int k = 0; k < NV; k++) begin
            ent = TBL[k];
            g = 0; e = 0; b = 0; en = 0; lat = 0;
            unique case (ent[14:12])
                OP_AACQ: agt_acq(g, lat);
                OP_AREL: rel_pulse(1'b0, en, sr, lp);
                OP_HACK: hst_acq(1, g, e, b, en, lat);
                OP_HNAK: hst_acq(2, g, e, b, en, lat);
                OP_HREL: rel_pulse(1'b1, en, sr, lp);
                default: ;
            endcase
            checks++;
            if ({g, e, b, en, 8'(lat)} != ent[11:0]) begin
                errors++;
                $display("FAIL R%0d vector %0d actual=%03h expected=%03h",
                         ent[18:15], k, {g, e, b, en, 8'(lat)}, ent[11:0]);
            end
        end

        // R3: host blocked while agent holds
        agt_acq(g, lat);
        hst_req = 1'b1;
        saw = 0;
        repeat (6) begin
            @(negedge clk);
            if (evt_begin || hst_gnt || sem_req) saw = 1;
        end
        check("R3 host held off by agent", saw, 0);
        @(posedge clk); #1;
        rel_pulse(1'b0, en, sr, lp);
        hst_acq(1, g, e, b, en, lat);
        check("R3 host proceeds after agent release", {g, b}, 2'b11);

        // R4: inhibit and semaphore held during ownership; R6 agent blocked
        agt_req = 1'b1;
        saw = 0;
        repeat (6) begin
            @(negedge clk);
            if (agt_gnt) saw = 1;
            if (!(sem_req && lp_inhibit)) saw = 1;
        end
        check("R6 agent not granted while host owns", saw, 0);
        @(posedge clk); #1;
        rel_pulse(1'b1, en, sr, lp);
        // R7 end cycle values
        check("R7 end pulse with semaphore and inhibit low", {en, sr, lp}, 3'b100);
        agt_acq(g, lat);
        check("R6 agent granted after host end", g, 1);
        rel_pulse(1'b0, en, sr, lp);

        // R11: simultaneous requests, agent wins
        agt_req = 1'b1; hst_req = 1'b1;
        @(negedge clk);
        check("R11 agent wins tie", {agt_gnt, hst_gnt}, 2'b10);
        @(posedge clk); #1;
        agt_req = 1'b0;
        saw = 0;
        repeat (3) begin
            @(negedge clk);
            if (evt_begin) saw = 1;
        end
        check("R11 host waits after tie", saw, 0);
        @(posedge clk); #1;
        rel_pulse(1'b0, en, sr, lp);
        hst_acq(1, g, e, b, en, lat);
        check("R11 host served after agent", {g, b}, 2'b11);
        rel_pulse(1'b1, en, sr, lp);

        // R9: timeout
        hst_acq(0, g, e, b, en, lat);
        check("R9 timeout error and end", {g, e, b, en}, 4'b0111);
        check("R9 timeout latency", lat, 4 + TMO);

        // R10: underflow flags (also proves R9 left host count at zero)
        check("R10 flags clear before", {agt_uflow, hst_uflow}, 2'b00);
        rel_pulse(1'b0, en, sr, lp);
        check("R10 agent release at zero", {agt_uflow, hst_uflow}, 2'b10);
        rel_pulse(1'b1, en, sr, lp);
        check("R10 host release at zero", {agt_uflow, hst_uflow, en}, 3'b110);
        hst_acq(1, g, e, b, en, lat);
        check("R10 host count unchanged by underflow", {g, b, lat[7:0]}, {2'b11, 8'd4});
        rel_pulse(1'b1, en, sr, lp);
        check("R10 flags sticky", {agt_uflow, hst_uflow, en}, 3'b111);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule